// File: doc/BRIEF.md
# Sixteen-Channel Switch Command Decoder and Diagnosis Formatter

This block sits behind a serial shift interface and drives sixteen low-side switch channels. Each time the shifter delivers a complete 16-bit word (a one-cycle `frame_valid` strobe), the upper byte is decoded as a command and the lower byte carries data for one group of eight channels. The block then registers the word that the shifter will send back during the following frame. The block keeps a group pointer that alternates between channels 1–8 and channels 9–16 on successive accepted frames, so a full view of all sixteen channels takes two frames.

Eight of the channels (1–4 and 9–12) also have a parallel input pin. In the two combining modes, that pin is merged with the channel's serial bit, by OR or by AND. The other eight channels follow their serial bit only. The protection logic supplies a two-bit fault code per channel. These codes feed the diagnosis replies and an active-low summary fault flag.

The defaults for the command byte values are: full diagnosis 0x90, one-bit diagnosis 0x60, echo 0xA5, OR write 0x30 and AND write 0x50. Any other upper byte is an unknown command.

Top module: `msw_switch_ctrl`

## Requirements
- R1: Fault codes are 11 normal, 10 open load, 01 short to ground, 00 overload or short to battery. After a full-diagnosis frame (command 0x90), `so_word[2k+1:2k]` holds the code of channel k of the group that the next frame will address.
- R2: After reset the group pointer addresses channels 1–8. Each accepted frame moves it to the other group. Each diagnosis reply covers the group that has just become current.
- R3: After a one-bit diagnosis frame (command 0x60), `so_word[15:8]` equals `par_in`. `so_word[k]` for k below 8 is 1 exactly when channel k of the new group has code 11.
- R4: After an echo frame (command 0xA5), `so_word` equals the whole received word.
- R5: An OR write (command 0x30) stores bit k of the lower byte as the serial bit of channel k of the current group. It selects OR combining, so a parallel-capable channel is on when its pin or its serial bit is 1. The reply is full diagnosis.
- R6: An AND write (command 0x50) stores the serial bits in the same way and selects AND combining, so a parallel-capable channel is on only when both its pin and its serial bit are 1.
- R7: `par_in[3:0]` drive channels 1–4 and `par_in[7:4]` drive channels 9–12. Channels 5–8 and 13–16 follow their serial bit only, whatever the pins do.
- R8: `fault_n` is low, combinationally, whenever any channel's code differs from 11.
- R9: While `rst_n` is low all of `chan_on` is 0. After reset the serial bits are 0, OR combining is selected and `so_word` is 0.
- R10: A frame whose upper byte is not a known command is ignored. `so_word`, the group pointer, the serial bits and the combining mode keep their values.
- R11: Diagnosis and echo frames leave the serial bits and the combining mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also forces all channels off |
| frame_valid | input | 1 | One-cycle strobe: `frame_word` holds a complete received word |
| frame_word | input | 16 | Received word: command byte over group data byte |
| par_in | input | 8 | Parallel pins: [3:0] channels 1–4, [7:4] channels 9–12 |
| fault_code | input | 32 | Two-bit code per channel, channel i at [2i+1:2i] |
| chan_on | output | 16 | Channel enables, channel i+1 at bit i |
| fault_n | output | 1 | Active-low summary fault flag |
| so_word | output | 16 | Word to be shifted out during the next frame |

## Verification
The reply formatter and the channel writer act on the same edge. An OR or AND write stores serial bits for the current group, and in that same cycle the reply must already describe the other group. The bench provokes this by sending write frames with distinct parallel-pin patterns. For each frame it compares `so_word` with the other group's codes, and compares `chan_on` with the merge of the new serial bits and the pins.

A second collision arises when the pins change in the cycle a diagnosis frame lands. The outputs must then move with the pins alone, while the serial state stays as it was.

// File: rtl/msw_pkg.sv
package msw_pkg;
   localparam int CODE_W = 2;

   localparam logic [CODE_W-1:0] CODE_OK   = 2'b11;
   localparam logic [CODE_W-1:0] CODE_OPEN = 2'b10;
   localparam logic [CODE_W-1:0] CODE_SCG  = 2'b01;
   localparam logic [CODE_W-1:0] CODE_OVL  = 2'b00;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_DIAG2 = 3'd1,
      OP_DIAG1 = 3'd2,
      OP_ECHO  = 3'd3,
      OP_OR    = 3'd4,
      OP_AND   = 3'd5
   } op_e;

   typedef enum logic {
      COMB_OR  = 1'b0,
      COMB_AND = 1'b1
   } comb_e;

   function automatic logic op_writes(input op_e op);
      return (op == OP_OR) || (op == OP_AND);
   endfunction
endpackage

// File: rtl/msw_cmd_decode.sv
module msw_cmd_decode
   import msw_pkg::*;
#(
   parameter int         CMD_W     = 8,
   parameter logic [7:0] CMD_DIAG2 = 8'h90,
   parameter logic [7:0] CMD_DIAG1 = 8'h60,
   parameter logic [7:0] CMD_ECHO  = 8'hA5,
   parameter logic [7:0] CMD_OR    = 8'h30,
   parameter logic [7:0] CMD_AND   = 8'h50
) (
   input  logic [CMD_W-1:0] cmd,
   output op_e              op,
   output logic             known
);
   if (CMD_W != 8) begin : g_bad_cmd_w
      $error("msw_cmd_decode: command field must be 8 bits");
   end

   always_comb begin
      case (cmd)
         CMD_DIAG2: op = OP_DIAG2;
         CMD_DIAG1: op = OP_DIAG1;
         CMD_ECHO:  op = OP_ECHO;
         CMD_OR:    op = OP_OR;
         CMD_AND:   op = OP_AND;
         default:   op = OP_NONE;
      endcase
      known = (op != OP_NONE);
   end
endmodule

// File: rtl/msw_diag_fmt.sv
module msw_diag_fmt
   import msw_pkg::*;
#(
   parameter int NCH    = 16,
   parameter int GRP_W  = 8,
   parameter int WORD_W = 16,
   parameter int PAR_W  = 8,
   parameter int GPTR_W = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  op_e                   op,
   input  logic [WORD_W-1:0]     word,
   input  logic [GPTR_W-1:0]     next_grp,
   input  logic [NCH*CODE_W-1:0] fault_code,
   input  logic [PAR_W-1:0]      par_in,
   output logic [WORD_W-1:0]     so_word
);
   localparam int GC_W = GRP_W * CODE_W;

   if (GC_W != WORD_W) begin : g_bad_diag2
      $error("msw_diag_fmt: two-bit reply must fill the word");
   end
   if (PAR_W + GRP_W != WORD_W) begin : g_bad_diag1
      $error("msw_diag_fmt: one-bit reply must fill the word");
   end

   logic [GC_W-1:0]   grp_codes;
   logic [GRP_W-1:0]  ok_bits;
   logic [WORD_W-1:0] reply_d;

   assign grp_codes = fault_code[next_grp*GC_W +: GC_W];

   for (genvar k = 0; k < GRP_W; k++) begin : g_okbit
      assign ok_bits[k] = (grp_codes[k*CODE_W +: CODE_W] == CODE_OK);
   end

   always_comb begin
      case (op)
         OP_ECHO:  reply_d = word;
         OP_DIAG1: reply_d = {par_in, ok_bits};
         OP_NONE:  reply_d = so_word;
         default:  reply_d = grp_codes;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      so_word <= '0;
      else if (accept) so_word <= reply_d;
   end
endmodule

// File: rtl/msw_chan_ctrl.sv
module msw_chan_ctrl
   import msw_pkg::*;
#(
   parameter int NCH         = 16,
   parameter int GRP_W       = 8,
   parameter int PAR_PER_GRP = 4,
   parameter int GPTR_W      = 1,
   localparam int NGRP       = NCH / GRP_W,
   localparam int PAR_W      = NGRP * PAR_PER_GRP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  op_e               op,
   input  logic [GRP_W-1:0]  data,
   input  logic [GPTR_W-1:0] grp,
   input  logic [PAR_W-1:0]  par_in,
   output logic [NCH-1:0]    chan_on
);
   if (PAR_PER_GRP > GRP_W) begin : g_bad_par
      $error("msw_chan_ctrl: more parallel pins than channels per group");
   end

   logic [NCH-1:0] ser_q;
   comb_e          mode_q;
   logic [NCH-1:0] raw_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_q  <= '0;
         mode_q <= COMB_OR;
      end else if (accept && op_writes(op)) begin
         ser_q[grp*GRP_W +: GRP_W] <= data;
         mode_q <= (op == OP_AND) ? COMB_AND : COMB_OR;
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int G = i / GRP_W;
      localparam int K = i % GRP_W;
      if (K < PAR_PER_GRP) begin : g_par
         logic pin;
         assign pin = par_in[G*PAR_PER_GRP + K];
         assign raw_on[i] = (mode_q == COMB_AND) ? (pin & ser_q[i])
                                                 : (pin | ser_q[i]);
      end else begin : g_ser
         assign raw_on[i] = ser_q[i];
      end
   end

   assign chan_on = rst_n ? raw_on : '0;
endmodule

// File: rtl/msw_switch_ctrl.sv
module msw_switch_ctrl
   import msw_pkg::*;
#(
   parameter int         NCH         = 16,
   parameter int         GRP_W       = 8,
   parameter int         WORD_W      = 16,
   parameter int         PAR_PER_GRP = 4,
   parameter logic [7:0] CMD_DIAG2   = 8'h90,
   parameter logic [7:0] CMD_DIAG1   = 8'h60,
   parameter logic [7:0] CMD_ECHO    = 8'hA5,
   parameter logic [7:0] CMD_OR      = 8'h30,
   parameter logic [7:0] CMD_AND     = 8'h50,
   localparam int NGRP   = NCH / GRP_W,
   localparam int PAR_W  = NGRP * PAR_PER_GRP,
   localparam int CMD_W  = WORD_W - GRP_W,
   localparam int GPTR_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_valid,
   input  logic [WORD_W-1:0]     frame_word,
   input  logic [PAR_W-1:0]      par_in,
   input  logic [NCH*CODE_W-1:0] fault_code,
   output logic [NCH-1:0]        chan_on,
   output logic                  fault_n,
   output logic [WORD_W-1:0]     so_word
);
   if (NCH % GRP_W != 0) begin : g_bad_grp
      $error("msw_switch_ctrl: channel count must be a multiple of group size");
   end

   op_e               op;
   logic              known;
   logic              accept;
   logic [GPTR_W-1:0] grp_q;
   logic [GPTR_W-1:0] next_grp;
   logic [NCH-1:0]    ch_bad;

   msw_cmd_decode #(
      .CMD_W(CMD_W), .CMD_DIAG2(CMD_DIAG2), .CMD_DIAG1(CMD_DIAG1),
      .CMD_ECHO(CMD_ECHO), .CMD_OR(CMD_OR), .CMD_AND(CMD_AND)
   ) u_dec (
      .cmd  (frame_word[WORD_W-1 -: CMD_W]),
      .op   (op),
      .known(known)
   );

   assign accept   = frame_valid && known;
   assign next_grp = (grp_q == GPTR_W'(NGRP-1)) ? '0 : grp_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      grp_q <= '0;
      else if (accept) grp_q <= next_grp;
   end

   msw_diag_fmt #(
      .NCH(NCH), .GRP_W(GRP_W), .WORD_W(WORD_W), .PAR_W(PAR_W), .GPTR_W(GPTR_W)
   ) u_fmt (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .op        (op),
      .word      (frame_word),
      .next_grp  (next_grp),
      .fault_code(fault_code),
      .par_in    (par_in),
      .so_word   (so_word)
   );

   msw_chan_ctrl #(
      .NCH(NCH), .GRP_W(GRP_W), .PAR_PER_GRP(PAR_PER_GRP), .GPTR_W(GPTR_W)
   ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .op     (op),
      .data   (frame_word[GRP_W-1:0]),
      .grp    (grp_q),
      .par_in (par_in),
      .chan_on(chan_on)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_flt
      assign ch_bad[i] = (fault_code[i*CODE_W +: CODE_W] != CODE_OK);
   end
   assign fault_n = ~|ch_bad;
endmodule

// File: rtl/msw_switch_ctrl_chk.sv
module msw_switch_ctrl_chk #(
   parameter int         NCH       = 16,
   parameter int         WORD_W    = 16,
   parameter int         PAR_W     = 8,
   parameter int         GPTR_W    = 1,
   parameter logic [7:0] CMD_DIAG2 = 8'h90,
   parameter logic [7:0] CMD_DIAG1 = 8'h60,
   parameter logic [7:0] CMD_ECHO  = 8'hA5,
   parameter logic [7:0] CMD_OR    = 8'h30,
   parameter logic [7:0] CMD_AND   = 8'h50
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_valid,
   input logic [WORD_W-1:0] frame_word,
   input logic [PAR_W-1:0]  par_in,
   input logic [2*NCH-1:0]  fault_code,
   input logic [NCH-1:0]    chan_on,
   input logic              fault_n,
   input logic [WORD_W-1:0] so_word,
   input logic [GPTR_W-1:0] grp_q
);
   logic [7:0] cmd;
   logic       cmd_known;
   logic       cmd_diag;

   assign cmd       = frame_word[WORD_W-1 -: 8];
   assign cmd_diag  = (cmd == CMD_DIAG2) || (cmd == CMD_DIAG1) || (cmd == CMD_ECHO);
   assign cmd_known = cmd_diag || (cmd == CMD_OR) || (cmd == CMD_AND);

   always_comb begin
      if (!rst_n) begin
         p_reset_off_r9: assert (chan_on == '0);
      end
   end

   p_echo_reply_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && cmd == CMD_ECHO) |=> (so_word == $past(frame_word)));

   p_group_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && cmd_known) |=> (grp_q != $past(grp_q)));

   p_unknown_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && !cmd_known) |=> ($stable(so_word) && $stable(grp_q)));

   p_fault_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_code != {2*NCH{1'b1}}) |-> !fault_n);

   p_diag_keeps_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && cmd_diag) |=> ($stable(par_in) -> $stable(chan_on)));
endmodule

bind msw_switch_ctrl msw_switch_ctrl_chk #(
   .NCH(NCH), .WORD_W(WORD_W), .PAR_W(PAR_W), .GPTR_W(GPTR_W),
   .CMD_DIAG2(CMD_DIAG2), .CMD_DIAG1(CMD_DIAG1), .CMD_ECHO(CMD_ECHO),
   .CMD_OR(CMD_OR), .CMD_AND(CMD_AND)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_valid(frame_valid),
   .frame_word (frame_word),
   .par_in     (par_in),
   .fault_code (fault_code),
   .chan_on    (chan_on),
   .fault_n    (fault_n),
   .so_word    (so_word),
   .grp_q      (grp_q)
);

// File: tb/msw_switch_ctrl_tb.sv
`timescale 1ns/1ps
module msw_switch_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_valid = 1'b0;
   logic [15:0] frame_word = '0;
   logic [7:0]  par_in = '0;
   logic [31:0] fault_code = 32'h3EFF_FF1B;
   logic [15:0] chan_on;
   logic        fault_n;
   logic [15:0] so_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   msw_switch_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
      .frame_word(frame_word), .par_in(par_in), .fault_code(fault_code),
      .chan_on(chan_on), .fault_n(fault_n), .so_word(so_word)
   );

   // {word, par_in, expected so_word, expected chan_on}
   // group0 codes give 16'hFF1B, group1 codes give 16'h3EFF
   localparam logic [55:0] VEC [10] = '{
      {16'h9000, 8'h00, 16'h3EFF, 16'h0000},
      {16'h9000, 8'h00, 16'hFF1B, 16'h0000},
      {16'h30F0, 8'h01, 16'h3EFF, 16'h00F1},
      {16'h3003, 8'h40, 16'hFF1B, 16'h07F0},
      {16'h6000, 8'hA5, 16'hA56F, 16'h0BF5},
      {16'h5001, 8'h30, 16'hFF1B, 16'h01F0},
      {16'hA5C3, 8'h30, 16'hA5C3, 16'h01F0},
      {16'h7711, 8'h30, 16'hA5C3, 16'h01F0},
      {16'h9000, 8'hFF, 16'hFF1B, 16'h01F0},
      {16'h3000, 8'h00, 16'h3EFF, 16'h0100}
   };
   localparam string TAG [10] = '{
      "R1 R2", "R1 R2", "R5", "R5", "R3", "R6", "R4", "R10", "R11", "R5"
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w, input logic [7:0] p);
      @(negedge clk);
      frame_word  = w;
      par_in      = p;
      frame_valid = 1'b1;
      @(negedge clk);
      frame_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // reset state, R9
      repeat (3) @(negedge clk);
      check("R9 reset chan_on", 32'(chan_on), 32'h0);
      check("R9 reset so_word", 32'(so_word), 32'h0);
      check("R8 fault flag with faults", 32'(fault_n), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 10; i++) begin
         send(VEC[i][55:40], VEC[i][39:32]);
         check({TAG[i], " so_word"}, 32'(so_word), 32'(VEC[i][31:16]));
         check({TAG[i], " chan_on"}, 32'(chan_on), 32'(VEC[i][15:0]));
      end

      // R7: pins drive only channels 1-4 and 9-12 (OR mode, serial ch9 set)
      par_in = 8'hFF;
      @(negedge clk);
      check("R7 pin mapping", 32'(chan_on), 32'h0F0F);

      // R8: summary flag follows codes combinationally
      fault_code = 32'hFFFF_FFFF;
      #1;
      check("R8 no fault", 32'(fault_n), 32'h1);
      fault_code = 32'hBFFF_FFFF;
      #1;
      check("R8 open load ch16", 32'(fault_n), 32'h0);
      fault_code = 32'hFFFF_FFFC;
      #1;
      check("R8 overload ch1", 32'(fault_n), 32'h0);

      // R9: reset forces outputs off and restores OR mode, group and reply
      @(negedge clk);
      fault_code = 32'h3EFF_FF1B;
      par_in = 8'hFF;
      rst_n = 1'b0;
      #1;
      check("R9 off in reset", 32'(chan_on), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      par_in = 8'h01;
      @(negedge clk);
      check("R9 OR mode after reset", 32'(chan_on), 32'h0001);
      check("R9 so_word after reset", 32'(so_word), 32'h0);
      send(16'h9000, 8'h01);
      check("R2 group after reset", 32'(so_word), 32'h3EFF);

      // R3: one-bit reply with all codes normal
      fault_code = 32'hFFFF_FFFF;
      send(16'h6000, 8'h5A);
      check("R3 one-bit all ok", 32'(so_word), 32'h5AFF);

      finish_run();
   end
endmodule